// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block collects single-cycle event pulses from the receive, transmit, bus and PHY logic of a network controller into a sticky 32-bit cause register. It drives one level interrupt line toward the host. Software sees three word registers through a plain read/write strobe port: the cause register, a per-bit mask and a global enable. Reading the cause register returns its contents and empties it in the same access. A cause that arrives during that read survives into the next read.

One cause bit is not stored at all. Bit 15 is computed as the OR of the stored bus, FIFO and reset-completion causes in bits 16 to 25. A driver can therefore unmask a single bit to hear about all of those rarer conditions. The line is registered and follows the masked, enabled cause state one clock later.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset, the cause, mask and enable registers all read zero and `irq_o` is low.
- R2: An `evt_i` pulse on a stored bit sets that cause bit. The bit stays set until the cause register (offset 0x10) is read. Stored bits are 0 to 14, 16 and 20 to 25.
- R3: Pulses on `evt_i` bits 15, 17 to 19 and 26 to 31 have no effect. Those cause bits, other than bit 15, always read zero.
- R4: Cause bit 15 reads as the OR of stored cause bits 16 to 25.
- R5: A read at offset 0x10 returns the cause value combinationally in the same cycle. From the next cycle on, every stored bit not pulsed in that cycle is clear.
- R6: An event pulsed in the same cycle as a cause read does not appear in that read's data. It does appear in the next cause read.
- R7: Writes to offset 0x10 leave the cause register unchanged.
- R8: The mask register at offset 0x14 holds only the stored bits plus bit 15, so it reads back as the written value AND 0x03F1_FFFF. The enable register at offset 0x18 holds only bit 0, and its other bits read zero.
- R9: `irq_o` is high in the cycle after a clock edge at which (cause AND mask) was nonzero and enable bit 0 was set. It is low otherwise. The cause value used here includes the derived bit 15.
- R10: Reads at any other offset return zero, and writes there change nothing. `rdata_o` is zero when `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one bit per cause |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request line |

## Verification
The hardest case to reach from the ports is an event that lands in exactly the cycle the cause register is read. Here the clear and the set compete in the same flop, and the outcome is only visible one read later. Directed steps place a pulse on the read cycle and then read again. The random phase then issues frequent reads while sparse random pulses arrive, so collisions on many bit positions occur without being aimed at. Directed steps also pulse each non-stored bit, and route a high-order bus error onto the interrupt line through the derived bit 15 alone.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
   localparam int unsigned  DW          = 32;
   localparam int unsigned  AW          = 8;
   localparam logic [31:0]  STORED_BITS = 32'h03F1_7FFF;
   localparam int unsigned  SUM_POS     = 15;
   localparam int unsigned  SUM_LO      = 16;
   localparam int unsigned  SUM_HI      = 25;
   localparam logic [7:0]   OFS_CAUSE   = 8'h10;
   localparam logic [7:0]   OFS_MASK    = 8'h14;
   localparam logic [7:0]   OFS_ENABLE  = 8'h18;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_CAUSE  = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_ENABLE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/nic_irq_decode.sv
module nic_irq_decode
   import nic_irq_pkg::*;
#(
   parameter int unsigned AW          = nic_irq_pkg::AW,
   parameter logic [AW-1:0] CAUSE_OFS  = AW'(OFS_CAUSE),
   parameter logic [AW-1:0] MASK_OFS   = AW'(OFS_MASK),
   parameter logic [AW-1:0] ENABLE_OFS = AW'(OFS_ENABLE)
) (
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   output reg_sel_e      sel_o,
   output logic          cause_rd_o,
   output logic          mask_wr_o,
   output logic          enable_wr_o
);
   initial begin
      assert (CAUSE_OFS != MASK_OFS && CAUSE_OFS != ENABLE_OFS && MASK_OFS != ENABLE_OFS)
         else $error("register offsets must be distinct");
   end

   always_comb begin
      sel_o = SEL_NONE;
      if (addr_i == CAUSE_OFS)       sel_o = SEL_CAUSE;
      else if (addr_i == MASK_OFS)   sel_o = SEL_MASK;
      else if (addr_i == ENABLE_OFS) sel_o = SEL_ENABLE;
   end

   assign cause_rd_o  = rd_i && (sel_o == SEL_CAUSE);
   assign mask_wr_o   = wr_i && (sel_o == SEL_MASK);
   assign enable_wr_o = wr_i && (sel_o == SEL_ENABLE);
endmodule

// File: rtl/nic_irq_cause.sv
module nic_irq_cause
   import nic_irq_pkg::*;
#(
   parameter int unsigned     DW      = nic_irq_pkg::DW,
   parameter logic [DW-1:0]   STORED  = DW'(STORED_BITS),
   parameter int unsigned     SUM_POS = nic_irq_pkg::SUM_POS,
   parameter int unsigned     SUM_LO  = nic_irq_pkg::SUM_LO,
   parameter int unsigned     SUM_HI  = nic_irq_pkg::SUM_HI
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] evt_i,
   input  logic          clr_i,
   output logic [DW-1:0] view_o
);
   localparam int unsigned SUM_W = SUM_HI - SUM_LO + 1;

   initial begin
      assert (SUM_LO <= SUM_HI && SUM_HI < DW && SUM_POS < DW)
         else $error("summary range outside the register");
      assert (STORED[SUM_POS] == 1'b0)
         else $error("summary bit must not be a stored bit");
      assert (SUM_W >= 1)
         else $error("summary range is empty");
   end

   logic [DW-1:0] cause_q;
   logic [DW-1:0] evt_kept;
   logic          summary;

   assign evt_kept = evt_i & STORED;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (STORED[b]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~clr_i) | evt_i[b];
         end
         assign cause_q[b] = bit_q;
      end else begin : g_tie
         assign cause_q[b] = 1'b0;
      end
   end

   assign summary = |cause_q[SUM_HI:SUM_LO];
   assign view_o  = cause_q | (DW'(summary) << SUM_POS);

   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && evt_kept == '0) |=> (cause_q == '0)) else $error("read did not clear"); // R5
   AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_kept != '0) |=> ((cause_q & $past(evt_kept)) == $past(evt_kept))) else $error("event lost"); // R6
   AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && evt_kept == '0) |=> $stable(cause_q)) else $error("cause changed idle"); // R7
endmodule

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl
   import nic_irq_pkg::*;
#(
   parameter int unsigned   DW       = nic_irq_pkg::DW,
   parameter logic [DW-1:0] MASKABLE = DW'(STORED_BITS) | (DW'(1) << SUM_POS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mask_wr_i,
   input  logic          enable_wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] mask_o,
   output logic          enable_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_o   <= '0;
         enable_o <= 1'b0;
      end else begin
         if (mask_wr_i)   mask_o   <= wdata_i & MASKABLE;
         if (enable_wr_i) enable_o <= wdata_i[0];
      end
   end
endmodule

// File: rtl/nic_irq_out.sv
module nic_irq_out #(
   parameter int unsigned DW      = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] cause_i,
   input  logic [DW-1:0] mask_i,
   input  logic          enable_i,
   output logic          irq_o
);
   logic pending;
   assign pending = enable_i && ((cause_i & mask_i) != '0);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= pending;
      end
      AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> $past(enable_i)) else $error("irq without enable"); // R9
   end else begin : g_comb
      assign irq_o = pending;
   end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
   import nic_irq_pkg::*;
#(
   parameter int unsigned DW      = nic_irq_pkg::DW,
   parameter int unsigned AW      = nic_irq_pkg::AW,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] evt_i,
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          irq_o
);
   initial begin
      assert (DW == 32) else $error("cause layout needs a 32-bit word");
      assert (AW >= 5)  else $error("address too narrow for offsets");
   end

   reg_sel_e      sel;
   logic          cause_rd, mask_wr, enable_wr;
   logic [DW-1:0] cause_view, mask_q;
   logic          enable_q;

   nic_irq_decode #(.AW(AW)) u_dec (
      .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .sel_o(sel),
      .cause_rd_o(cause_rd), .mask_wr_o(mask_wr), .enable_wr_o(enable_wr)
   );

   nic_irq_cause #(.DW(DW)) u_cause (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(cause_rd), .view_o(cause_view)
   );

   nic_irq_ctl #(.DW(DW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .mask_wr_i(mask_wr), .enable_wr_i(enable_wr),
      .wdata_i(wdata_i), .mask_o(mask_q), .enable_o(enable_q)
   );

   nic_irq_out #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .cause_i(cause_view), .mask_i(mask_q),
      .enable_i(enable_q), .irq_o(irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         unique case (sel)
            SEL_CAUSE:  rdata_o = cause_view;
            SEL_MASK:   rdata_o = mask_q;
            SEL_ENABLE: rdata_o = DW'(enable_q);
            default:    rdata_o = '0;
         endcase
      end
   end

   AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |-> (rdata_o == '0)) else $error("data without read"); // R10
endmodule

// File: tb/sim_nic_irq_ctrl.sv
module sim_nic_irq_ctrl;
   localparam logic [31:0] STORED = 32'h03F1_7FFF;
   localparam logic [31:0] MASKW  = 32'h03F1_FFFF;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] evt_i, wdata_i;
   logic        rd_i, wr_i;
   logic [7:0]  addr_i;
   logic [31:0] rdata_o;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [31:0] m_cause, m_mask;
   logic        m_en, m_irq;

   always #4 clk = ~clk;

   nic_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_i(rd_i), .wr_i(wr_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
   );

   function automatic logic [31:0] view(input logic [31:0] c);
      return c | ({31'b0, |c[25:16]} << 15);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h10:   return view(m_cause);
         8'h14:   return m_mask;
         8'h18:   return {31'b0, m_en};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input string req, input bit rd, input bit wr, input logic [7:0] a,
                       input logic [31:0] wd, input logic [31:0] ev);
      logic [31:0] erd;
      logic        nirq;
      rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd; evt_i = ev;
      #3;
      check(irq_o == m_irq, "R9", {31'b0, irq_o}, {31'b0, m_irq});
      erd = rd ? exp_read(a) : 32'h0;
      check(rdata_o == erd, req, rdata_o, erd);
      nirq = m_en && ((view(m_cause) & m_mask) != 0);
      if (wr && a == 8'h14) m_mask = wd & MASKW;
      if (wr && a == 8'h18) m_en = wd[0];
      m_cause = ((rd && a == 8'h10) ? 32'h0 : m_cause) | (ev & STORED);
      m_irq = nirq;
      @(posedge clk); #1;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; rd_i = 0; wr_i = 0; addr_i = 0; wdata_i = 0; evt_i = 0;
      m_cause = 0; m_mask = 0; m_en = 0; m_irq = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      step("R1", 1, 0, 8'h10, 0, 0);
      step("R1", 1, 0, 8'h14, 0, 0);
      step("R1", 1, 0, 8'h18, 0, 0);
      // R2: stored bit sticks until read
      step("R2", 0, 0, 8'h00, 0, 32'h0000_0008);
      step("R2", 0, 0, 8'h00, 0, 0);
      step("R2", 1, 0, 8'h10, 0, 0);
      step("R5", 1, 0, 8'h10, 0, 0);
      // R3: unstored positions ignored
      step("R3", 0, 0, 8'h00, 0, 32'hFC0E_8000);
      step("R3", 1, 0, 8'h10, 0, 0);
      // R4: derived bit 15
      step("R4", 0, 0, 8'h00, 0, 32'h0040_0000);
      step("R4", 1, 0, 8'h10, 0, 0);
      // R6: pulse during the read
      step("R6", 0, 0, 8'h00, 0, 32'h0000_4000);
      step("R6", 1, 0, 8'h10, 0, 32'h0000_0002);
      step("R6", 1, 0, 8'h10, 0, 0);
      // R7: writes to cause ignored
      step("R7", 0, 0, 8'h00, 0, 32'h0000_0020);
      step("R7", 0, 1, 8'h10, 32'hFFFF_FFFF, 0);
      step("R7", 1, 0, 8'h10, 0, 0);
      // R8: mask and enable widths
      step("R8", 0, 1, 8'h14, 32'hFFFF_FFFF, 0);
      step("R8", 1, 0, 8'h14, 0, 0);
      step("R8", 0, 1, 8'h18, 32'hFFFF_FFFE, 0);
      step("R8", 1, 0, 8'h18, 0, 0);
      step("R8", 0, 1, 8'h18, 32'h0000_0003, 0);
      step("R8", 1, 0, 8'h18, 0, 0);
      // R9: irq through bit 15 alone
      step("R9", 0, 1, 8'h14, 32'h0000_8000, 0);
      step("R9", 0, 0, 8'h00, 0, 32'h0100_0000);
      step("R9", 0, 0, 8'h00, 0, 0);
      step("R9", 0, 0, 8'h00, 0, 0);
      step("R9", 1, 0, 8'h10, 0, 0);
      step("R9", 0, 0, 8'h00, 0, 0);
      step("R9", 0, 1, 8'h18, 32'h0, 32'h0020_0000);
      step("R9", 0, 0, 8'h00, 0, 0);
      // R10: other offsets
      step("R10", 0, 1, 8'h1C, 32'hFFFF_FFFF, 0);
      step("R10", 1, 0, 8'h1C, 0, 0);
      step("R10", 1, 0, 8'h00, 0, 0);
      step("R10", 1, 0, 8'h14, 0, 0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] ev;
         logic [7:0]  a;
         int k;
         ev = $urandom & $urandom & $urandom & $urandom;
         k = $urandom_range(0, 3);
         a = 8'h10 + 8'(k * 4);
         step("R5", ($urandom_range(0, 2) == 0), ($urandom_range(0, 5) == 0), a, $urandom, ev);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule